// File: doc/BRIEF.md
# Truncated-Phase Numerically Controlled Oscillator

This block is the digital core of a direct digital synthesis source. A wide phase accumulator advances once per reference clock by a phase increment (the frequency word). Only the most significant `ADDR_W` bits of the accumulator address a waveform memory. The low bits are never used as an address, but they keep accumulating, so the fine frequency resolution `fc / 2^PHASE_W` is preserved. The output frequency is `inc * fc / 2^PHASE_W`.

The frequency word is written by a host into a holding register. It reaches the accumulator only when a load strobe copies it into the active increment register, and the accumulator phase is not disturbed when this happens. The waveform memory holds `2^SEL_W` tables, for example sine, triangle, square and a modulated shape. The table-select input forms the address bits above the phase bits, so the output shape can change on any cycle. A host write port fills the tables while the oscillator runs.

A small control state machine sequences start-up. `CTL_PRIME` is the state held during and just after reset. In it the accumulator stays at zero while the first read of phase zero is issued. The transition PRIME→SPIN happens on the first clock edge without reset. The transition SPIN→SPIN repeats for as long as reset stays low. Reset returns the machine to PRIME from either state.

Top module: `nco_core`

## Requirements
- R1: While `rst` is high, `sample_vld_o` is 0 after every clock edge.
- R2: On the first edge after reset is released, the block reads table entry 0 of the selected table (phase zero) and `sample_vld_o` goes high. It then stays high until the next reset.
- R3: In the SPIN state, the accumulator adds the active increment on every edge, modulo 2^PHASE_W, with no saturation. The memory address is `{tbl_sel_i, acc[PHASE_W-1 -: ADDR_W]}`.
- R4: The low PHASE_W-ADDR_W accumulator bits keep accumulating, so an increment of 2^(PHASE_W-ADDR_W-1) advances the address once every two cycles.
- R5: `freq_wr_i` loads `freq_word_i` into the holding register only. The output frequency does not change until a load.
- R6: `freq_load_i` copies the holding register into the active increment. The new increment is applied from the next edge, and the accumulator keeps its phase.
- R7: When `freq_wr_i` and `freq_load_i` are high in the same cycle, the load takes the holding value from before that write.
- R8: A change of `tbl_sel_i` takes effect on the sample produced by the next edge and does not disturb the phase.
- R9: The read latency is one cycle: `sample_o` after edge n is the memory word at the address present before edge n.
- R10: A host write and a read to the same address in the same cycle return the old word. The new word is returned on the next read.
- R11: Host writes during operation do not alter the phase sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | reference clock |
| rst | input | 1 | synchronous reset, active high |
| freq_wr_i | input | 1 | write `freq_word_i` into the holding register |
| freq_word_i | input | PHASE_W | new phase increment |
| freq_load_i | input | 1 | copy the holding register into the active increment |
| tbl_sel_i | input | SEL_W | waveform table select (high address bits) |
| wr_en_i | input | 1 | waveform memory write enable |
| wr_addr_i | input | SEL_W+ADDR_W | waveform memory write address |
| wr_data_i | input | SAMP_W | waveform memory write data |
| sample_o | output | SAMP_W | sample for the converter |
| sample_vld_o | output | 1 | `sample_o` holds a valid sample |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a holding-register write together with a load strobe. The bench drives both in one cycle after priming the holding register with a different word, then checks that the address step matches the earlier word. The second pair is a host write together with a read of the same word. The bench freezes the phase with a zero increment and writes exactly the address being read. It expects the old word first and the new word one cycle later.

// File: rtl/nco_pkg.sv
package nco_pkg;
    // start-up sequencing of the oscillator
    typedef enum logic [0:0] {
        CTL_PRIME = 1'b0,
        CTL_SPIN  = 1'b1
    } ctl_state_t;
endpackage

// File: rtl/nco_incr_latch.sv
module nco_incr_latch #(
    parameter int PHASE_W = 40
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_i,
    input  logic [PHASE_W-1:0] word_i,
    input  logic               load_i,
    output logic [PHASE_W-1:0] hold_o,
    output logic [PHASE_W-1:0] active_o
);
    logic [PHASE_W-1:0] hold_q;
    logic [PHASE_W-1:0] active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q   <= '0;
            active_q <= '0;
        end else begin
            // load sees the holding value from before any same-cycle write
            if (load_i) active_q <= hold_q;
            if (wr_i)   hold_q   <= word_i;
        end
    end

    assign hold_o   = hold_q;
    assign active_o = active_q;
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int PHASE_W = 40
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step_en_i,
    input  logic [PHASE_W-1:0] inc_i,
    output logic [PHASE_W-1:0] acc_o
);
    logic [PHASE_W-1:0] acc_q;

    // modulo-2^PHASE_W wrap is the natural carry drop
    always_ff @(posedge clk) begin
        if (rst)            acc_q <= '0;
        else if (step_en_i) acc_q <= acc_q + inc_i;
    end

    assign acc_o = acc_q;
endmodule

// File: rtl/nco_wave_ram.sv
module nco_wave_ram #(
    parameter int AW = 10,
    parameter int DW = 14
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_q;

    // read-before-write: a colliding read returns the stored word
    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
        rdata_q <= mem[raddr_i];
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/nco_core.sv
module nco_core #(
    parameter int PHASE_W = 40,
    parameter int ADDR_W  = 8,
    parameter int SAMP_W  = 14,
    parameter int SEL_W   = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    freq_wr_i,
    input  logic [PHASE_W-1:0]      freq_word_i,
    input  logic                    freq_load_i,
    input  logic [SEL_W-1:0]        tbl_sel_i,
    input  logic                    wr_en_i,
    input  logic [SEL_W+ADDR_W-1:0] wr_addr_i,
    input  logic [SAMP_W-1:0]       wr_data_i,
    output logic [SAMP_W-1:0]       sample_o,
    output logic                    sample_vld_o
);
    import nco_pkg::*;

    localparam int MEM_AW = SEL_W + ADDR_W;

    ctl_state_t         ctl_state;
    ctl_state_t         ctl_next;
    logic               step_en;
    logic               vld_set;
    logic               vld_q;
    logic [PHASE_W-1:0] inc_hold;
    logic [PHASE_W-1:0] inc_active;
    logic [PHASE_W-1:0] phase_acc;
    logic [MEM_AW-1:0]  rd_addr;

    // state register
    always_ff @(posedge clk) begin
        if (rst) ctl_state <= CTL_PRIME;
        else     ctl_state <= ctl_next;
    end

    // next state
    always_comb begin
        ctl_next = ctl_state;
        unique case (ctl_state)
            CTL_PRIME: ctl_next = CTL_SPIN;
            CTL_SPIN:  ctl_next = CTL_SPIN;
            default:   ctl_next = CTL_PRIME;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        step_en = 1'b0;
        vld_set = 1'b0;
        unique case (ctl_state)
            CTL_PRIME: begin
                step_en = 1'b0;
                vld_set = 1'b1;
            end
            CTL_SPIN: begin
                step_en = 1'b1;
                vld_set = 1'b1;
            end
            default: begin
                step_en = 1'b0;
                vld_set = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)          vld_q <= 1'b0;
        else if (vld_set) vld_q <= 1'b1;
    end

    nco_incr_latch #(.PHASE_W(PHASE_W)) u_incr (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (freq_wr_i),
        .word_i   (freq_word_i),
        .load_i   (freq_load_i),
        .hold_o   (inc_hold),
        .active_o (inc_active)
    );

    nco_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .step_en_i (step_en),
        .inc_i     (inc_active),
        .acc_o     (phase_acc)
    );

    // truncation: table select on top, phase MSBs below
    assign rd_addr = {tbl_sel_i, phase_acc[PHASE_W-1 -: ADDR_W]};

    nco_wave_ram #(.AW(MEM_AW), .DW(SAMP_W)) u_ram (
        .clk     (clk),
        .we_i    (wr_en_i),
        .waddr_i (wr_addr_i),
        .wdata_i (wr_data_i),
        .raddr_i (rd_addr),
        .rdata_o (sample_o)
    );

    assign sample_vld_o = vld_q;
endmodule

// File: rtl/nco_core_chk.sv
module nco_core_chk #(
    parameter int PHASE_W = 40
) (
    input logic                clk,
    input logic                rst,
    input logic                freq_wr_i,
    input logic [PHASE_W-1:0]  freq_word_i,
    input logic                freq_load_i,
    input logic                sample_vld_o,
    input nco_pkg::ctl_state_t ctl_state,
    input logic [PHASE_W-1:0]  inc_hold,
    input logic [PHASE_W-1:0]  inc_active,
    input logic [PHASE_W-1:0]  phase_acc
);
    import nco_pkg::*;

    logic [PHASE_W-1:0] acc_next_w;
    assign acc_next_w = phase_acc + inc_active;

    // R2
    prime_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_state == CTL_PRIME) |=> (ctl_state == CTL_SPIN && sample_vld_o));

    // R2
    prime_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_state == CTL_PRIME) |-> (phase_acc == '0));

    // R2
    vld_keep_chk: assert property (@(posedge clk) disable iff (rst)
        sample_vld_o |=> sample_vld_o);

    // R3
    spin_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_state == CTL_SPIN) |=> (phase_acc == $past(acc_next_w)));

    // R5
    hold_upd_chk: assert property (@(posedge clk) disable iff (rst)
        freq_wr_i |=> (inc_hold == $past(freq_word_i)));

    // R6
    inc_steady_chk: assert property (@(posedge clk) disable iff (rst)
        !freq_load_i |=> $stable(inc_active));

    // R7
    load_copy_chk: assert property (@(posedge clk) disable iff (rst)
        freq_load_i |=> (inc_active == $past(inc_hold)));
endmodule

bind nco_core nco_core_chk #(.PHASE_W(PHASE_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .freq_wr_i    (freq_wr_i),
    .freq_word_i  (freq_word_i),
    .freq_load_i  (freq_load_i),
    .sample_vld_o (sample_vld_o),
    .ctl_state    (ctl_state),
    .inc_hold     (inc_hold),
    .inc_active   (inc_active),
    .phase_acc    (phase_acc)
);

// File: tb/nco_core_tb_top.sv
`timescale 1ns/1ps
module nco_core_tb_top;
    localparam int PW = 40;
    localparam int AW = 8;
    localparam int DW = 14;
    localparam int SW = 2;
    localparam int TW = SW + AW;
    localparam int DEPTH = 1 << TW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          freq_wr = 1'b0;
    logic [PW-1:0] freq_word = '0;
    logic          freq_load = 1'b0;
    logic [SW-1:0] tbl_sel = '0;
    logic          wr_en = 1'b0;
    logic [TW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] sample_o;
    logic          sample_vld_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    nco_core #(.PHASE_W(PW), .ADDR_W(AW), .SAMP_W(DW), .SEL_W(SW)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .freq_wr_i    (freq_wr),
        .freq_word_i  (freq_word),
        .freq_load_i  (freq_load),
        .tbl_sel_i    (tbl_sel),
        .wr_en_i      (wr_en),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .sample_o     (sample_o),
        .sample_vld_o (sample_vld_o)
    );

    always #2.5 clk = ~clk;

    // behavioural expectation built from the requirements
    logic [DW-1:0] mm [DEPTH];
    logic [PW-1:0] m_acc = '0, m_inc = '0, m_hold = '0;
    logic          m_prime = 1'b1, m_vld = 1'b0;
    logic [DW-1:0] m_sample = '0;

    always @(posedge clk) begin
        if (!rst) begin
            m_sample = mm[{tbl_sel, m_acc[PW-1 -: AW]}];
            m_vld = 1'b1;
            if (!m_prime) m_acc = m_acc + m_inc;
            m_prime = 1'b0;
            if (freq_load) m_inc = m_hold;
            if (freq_wr)   m_hold = freq_word;
        end else begin
            m_acc = '0; m_inc = '0; m_hold = '0; m_prime = 1'b1; m_vld = 1'b0;
        end
        if (wr_en) mm[wr_addr] = wr_data;
    end

    function automatic logic [DW-1:0] fill_val(input int a);
        int v;
        v = a * 37 + 5;
        return v[DW-1:0];
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req);
        n_chk++;
        if (sample_vld_o !== m_vld || (m_vld && sample_o !== m_sample)) begin
            n_fail++;
            $display("FAIL %s: sample=%h vld=%b expected sample=%h vld=%b",
                     req, sample_o, sample_vld_o, m_sample, m_vld);
        end
    endtask

    task automatic chk_val(input string req, input logic [DW-1:0] exp);
        n_chk++;
        if (sample_vld_o !== 1'b1 || sample_o !== exp) begin
            n_fail++;
            $display("FAIL %s: sample=%h vld=%b expected sample=%h vld=1",
                     req, sample_o, sample_vld_o, exp);
        end
    endtask

    task automatic set_inc(input logic [PW-1:0] w);
        freq_wr = 1'b1; freq_word = w; tick();
        freq_wr = 1'b0; freq_load = 1'b1; tick();
        freq_load = 1'b0;
    endtask

    // R1: table fill during reset, valid must stay low
    task automatic sc_reset();
        for (int a = 0; a < DEPTH; a++) begin
            wr_en = 1'b1; wr_addr = TW'(a); wr_data = fill_val(a); tick();
        end
        wr_en = 1'b0;
        for (int i = 0; i < 3; i++) begin tick(); chk("R1"); end
    endtask

    // R2: first sample is phase zero of table 0
    task automatic sc_first();
        rst = 1'b0; tick();
        chk_val("R2", fill_val(0));
        tick(); chk_val("R2", fill_val(0));
    endtask

    // R3 / R9: one address per cycle
    task automatic sc_step();
        set_inc(PW'(1) << (PW - AW));
        for (int i = 0; i < 6; i++) begin tick(); chk("R3"); chk("R9"); end
    endtask

    // R4: fractional increment, address every two cycles
    task automatic sc_frac();
        set_inc(PW'(1) << (PW - AW - 1));
        for (int i = 0; i < 8; i++) begin tick(); chk("R4"); end
    endtask

    // R5 then R6
    task automatic sc_hold();
        freq_wr = 1'b1; freq_word = PW'(3) << (PW - AW); tick();
        freq_wr = 1'b0;
        for (int i = 0; i < 4; i++) begin tick(); chk("R5"); end
        freq_load = 1'b1; tick(); freq_load = 1'b0; chk("R6");
        for (int i = 0; i < 4; i++) begin tick(); chk("R6"); end
    endtask

    // R7: write and load in one cycle
    task automatic sc_collide();
        freq_wr = 1'b1; freq_word = PW'(5) << (PW - AW); tick();
        freq_word = PW'(2) << (PW - AW); freq_load = 1'b1; tick();
        freq_wr = 1'b0; freq_load = 1'b0;
        for (int i = 0; i < 4; i++) begin tick(); chk("R7"); end
    endtask

    // R3: wrap without saturation
    task automatic sc_wrap();
        set_inc({8'hFE, {(PW-8){1'b1}}});
        for (int i = 0; i < 10; i++) begin tick(); chk("R3"); end
    endtask

    // R8: table switch on the fly
    task automatic sc_sel();
        set_inc(PW'(1) << (PW - AW));
        tbl_sel = 2'd2; tick(); chk("R8");
        for (int i = 0; i < 3; i++) begin tick(); chk("R8"); end
        tbl_sel = 2'd3; tick(); chk("R8");
        tick(); chk("R8");
    endtask

    // R10: same-address write and read
    task automatic sc_ram();
        logic [TW-1:0] a;
        logic [DW-1:0] old;
        set_inc('0);
        tick(); tick();
        a = {tbl_sel, m_acc[PW-1 -: AW]};
        old = mm[a];
        wr_en = 1'b1; wr_addr = a; wr_data = ~old; tick();
        wr_en = 1'b0;
        chk_val("R10", old);
        tick(); chk_val("R10", ~old);
    endtask

    // R11: writes to another table while running
    task automatic sc_runwrite();
        set_inc(PW'(7) << (PW - AW - 2));
        for (int i = 0; i < 8; i++) begin
            wr_en = 1'b1; wr_addr = {2'd1, AW'(i)}; wr_data = DW'(i * 3); tick();
            chk("R11");
        end
        wr_en = 1'b0;
        tbl_sel = 2'd1;
        for (int i = 0; i < 6; i++) begin tick(); chk("R11"); end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected completion", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tick();
        sc_reset();
        sc_first();
        sc_step();
        sc_frac();
        sc_hold();
        sc_collide();
        sc_wrap();
        sc_sel();
        sc_ram();
        sc_runwrite();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule